// File: doc/BRIEF.md
# DRAM Bank Timing Tracker

This block keeps the per-bank state that a DRAM command scheduler needs before it can issue anything. For every bank in every rank it holds the open row, or a reserved all-ones value when the bank is closed. It also holds three countdowns: one until a column command may issue, one until a precharge may issue, and one until an activate may issue. Each rank has its own activate-to-activate spacing counter and a short history of recent activates. The history caps how many activates can land inside a rolling window.

The scheduler drives one command per cycle on a strobe bus that carries the kind, rank, bank and row. A command that is not currently legal is dropped. The block returns three per-bank ready vectors, a row lookup for one bank chosen by flat index, and a mask of the closed banks that can activate soonest. After a configured number of column accesses, a row is closed automatically, as if an auto-precharge had followed the last access.

Top module: `dramBankTracker`

## Requirements
- R1: After reset, or on leaving it, every bank is closed: the row lookup reports the all-ones row with `qryOpen` low. All `actReady` bits and all `earliestMask` bits are 1, and all `colReady` and `preReady` bits are 0.
- R2: `cmdKind` encodes 00 as no command, 01 as activate, 10 as column access and 11 as precharge. A legal activate issued in cycle n opens `cmdRow` in the bank from cycle n+1. That bank's `colReady` rises in cycle n+T_RCD.
- R3: After an activate in cycle n, `preReady` stays low until cycle max(previous precharge-allowed cycle, n+T_RAS). A legal precharge in cycle m closes the row from cycle m+1 and makes the bank activate-ready again in cycle m+T_RP.
- R4: Two activates to the same rank are at least T_RRD cycles apart. An activate in one rank does not delay activates in another rank.
- R5: No rank sees more than ACT_LIMIT activates inside any T_XAW-cycle window. The next activate waits until the oldest remembered activate plus T_XAW.
- R6: The MAX_COL-th column access to an open row closes it from the next cycle. The bank may activate again at max(precharge-allowed cycle, access cycle)+T_RP.
- R7: A command to a bank whose matching ready bit is low is ignored. So is an activate whose row is all ones. Such a command changes no output.
- R8: `earliestMask` has a 1 for exactly those closed banks whose remaining activate wait equals the smallest wait among closed banks. The wait of a bank is the largest of its own, its rank's spacing and its rank's window waits. The mask is 0 when no bank is closed.
- R9: Bank b of rank r has flat index r*BANKS_PER_RANK+b. That index is the bit position in every per-bank vector and the value used by `qryBank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdKind | input | 2 | Command kind: 00 none, 01 activate, 10 column, 11 precharge |
| cmdRank | input | RANK_W | Target rank |
| cmdBank | input | BANK_W | Target bank within the rank |
| cmdRow | input | ROW_W | Row to open on an activate |
| qryBank | input | IDX_W | Flat bank index for the row lookup |
| actReady | output | NUM_BANKS | Bank may take an activate this cycle |
| colReady | output | NUM_BANKS | Bank may take a column command this cycle |
| preReady | output | NUM_BANKS | Bank may take a precharge this cycle |
| earliestMask | output | NUM_BANKS | Closed banks with the smallest activate wait |
| qryOpen | output | 1 | Queried bank has a row open |
| qryRow | output | ROW_W | Open row of the queried bank, all ones when closed |

## Verification
The bench builds the block with two ranks of four banks, 6-bit rows, T_RCD=3, T_RP=3, T_RAS=6, T_RRD=2, T_XAW=10, ACT_LIMIT=2 and MAX_COL=4. With these values, a few thousand random command cycles often fill the two-entry window. They also often hit the forced close, draw the all-ones row by chance, and leave several banks tied for earliest activation. Every cycle, the bench compares all per-bank vectors, the mask and a rotating row lookup against a model kept in absolute cycle numbers.

// File: rtl/dbtPkg.sv
package dbtPkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_ACT  = 2'b01,
    CMD_COL  = 2'b10,
    CMD_PRE  = 2'b11
  } cmdKindT;

  // per-bank strobes from control to the bank datapath
  typedef struct packed {
    logic act;
    logic col;
    logic pre;
  } bankStrobeT;

endpackage

// File: rtl/dbtBankState.sv
module dbtBankState
  import dbtPkg::*;
#(
  parameter int ROW_W   = 10,
  parameter int CNT_W   = 5,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_RAS   = 6,
  parameter int MAX_COL = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  bankStrobeT       strobe,
  input  logic [ROW_W-1:0] actRow,
  output logic             rowOpen,
  output logic [ROW_W-1:0] openRow,
  output logic [CNT_W-1:0] actWait,
  output logic             colIdle,
  output logic             preIdle
);

  localparam int ACC_W = (MAX_COL > 1) ? $clog2(MAX_COL + 1) : 1;
  localparam logic [ROW_W-1:0] NO_ROW = '1;

  logic [ROW_W-1:0] rowQ;
  logic [CNT_W-1:0] colCnt, preCnt, actCnt;
  logic [ACC_W-1:0] accCnt;
  logic [CNT_W-1:0] preDec, rasLoad;

  function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  assign preDec  = dec(preCnt);
  assign rasLoad = CNT_W'(T_RAS - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ   <= NO_ROW;
      colCnt <= '0;
      preCnt <= '0;
      actCnt <= '0;
      accCnt <= '0;
    end else begin
      colCnt <= dec(colCnt);
      preCnt <= preDec;
      actCnt <= dec(actCnt);
      if (strobe.act) begin
        rowQ   <= actRow;
        colCnt <= CNT_W'(T_RCD - 1);
        preCnt <= (preDec > rasLoad) ? preDec : rasLoad;
        accCnt <= '0;
      end else if (strobe.pre) begin
        rowQ   <= NO_ROW;
        actCnt <= CNT_W'(T_RP - 1);
        accCnt <= '0;
      end else if (strobe.col) begin
        if (accCnt == ACC_W'(MAX_COL - 1)) begin
          // auto close: precharge lands once tRAS allows, then tRP
          rowQ   <= NO_ROW;
          actCnt <= preCnt + CNT_W'(T_RP - 1);
          accCnt <= '0;
        end else begin
          accCnt <= accCnt + 1'b1;
        end
      end
    end
  end

  assign rowOpen = (rowQ != NO_ROW);
  assign openRow = rowQ;
  assign actWait = actCnt;
  assign colIdle = (colCnt == '0);
  assign preIdle = (preCnt == '0);

  // R2: an activate strobe opens the requested row next cycle
  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.act |=> (rowOpen && rowQ == $past(actRow)));

  // R3: a precharge strobe leaves the bank closed
  p_pre_closes_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pre |=> !rowOpen);

  // R7: control only strobes a column when the bank is open and idle
  p_col_legal_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.col |-> (rowOpen && colCnt == '0));

  // R6: the access count never reaches the forced-close limit
  p_acc_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    accCnt < ACC_W'(MAX_COL));

endmodule

// File: rtl/dbtRankWindow.sv
module dbtRankWindow #(
  parameter int CNT_W     = 5,
  parameter int T_RRD     = 2,
  parameter int T_XAW     = 10,
  parameter int ACT_LIMIT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             actAny,
  output logic [CNT_W-1:0] rrdWait,
  output logic [CNT_W-1:0] xawWait
);

  localparam int PTR_W = (ACT_LIMIT > 1) ? $clog2(ACT_LIMIT) : 1;

  logic [CNT_W-1:0] rrdCnt;
  logic [CNT_W-1:0] slotQ [ACT_LIMIT];
  logic [PTR_W-1:0] wpQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrdCnt <= '0;
    end else if (actAny) begin
      rrdCnt <= CNT_W'(T_RRD - 1);
    end else if (rrdCnt != '0) begin
      rrdCnt <= rrdCnt - 1'b1;
    end
  end

  // circular history: each slot counts down the window of one activate
  for (genvar i = 0; i < ACT_LIMIT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotQ[i] <= '0;
      end else if (actAny && wpQ == PTR_W'(i)) begin
        slotQ[i] <= CNT_W'(T_XAW - 1);
      end else if (slotQ[i] != '0) begin
        slotQ[i] <= slotQ[i] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wpQ <= '0;
    end else if (actAny) begin
      wpQ <= (wpQ == PTR_W'(ACT_LIMIT - 1)) ? '0 : wpQ + 1'b1;
    end
  end

  assign rrdWait = rrdCnt;
  assign xawWait = slotQ[wpQ];

  // R4: no activate while the rank spacing counter runs
  p_rrd_spacing_r4: assert property (@(posedge clk) disable iff (!rstN)
    actAny |-> (rrdCnt == '0));

  // R5: no activate while the oldest remembered activate is inside the window
  p_window_limit_r5: assert property (@(posedge clk) disable iff (!rstN)
    actAny |-> (slotQ[wpQ] == '0));

endmodule

// File: rtl/dbtControl.sv
module dbtControl
  import dbtPkg::*;
#(
  parameter int NUM_RANKS      = 2,
  parameter int BANKS_PER_RANK = 4,
  parameter int ROW_W          = 10,
  parameter int CNT_W          = 5,
  localparam int NUM_BANKS = NUM_RANKS * BANKS_PER_RANK,
  localparam int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int BANK_W    = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1,
  localparam int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           cmdKind,
  input  logic [RANK_W-1:0]    cmdRank,
  input  logic [BANK_W-1:0]    cmdBank,
  input  logic [ROW_W-1:0]     cmdRow,
  input  logic [IDX_W-1:0]     qryBank,
  input  logic                 rowOpen [NUM_BANKS],
  input  logic [ROW_W-1:0]     openRow [NUM_BANKS],
  input  logic [CNT_W-1:0]     actWait [NUM_BANKS],
  input  logic                 colIdle [NUM_BANKS],
  input  logic                 preIdle [NUM_BANKS],
  input  logic [CNT_W-1:0]     rrdWait [NUM_RANKS],
  input  logic [CNT_W-1:0]     xawWait [NUM_RANKS],
  output bankStrobeT           strobe  [NUM_BANKS],
  output logic                 rankAct [NUM_RANKS],
  output logic [NUM_BANKS-1:0] actReady,
  output logic [NUM_BANKS-1:0] colReady,
  output logic [NUM_BANKS-1:0] preReady,
  output logic [NUM_BANKS-1:0] earliestMask,
  output logic                 qryOpen,
  output logic [ROW_W-1:0]     qryRow
);

  cmdKindT kindE;
  int cmdFlat;
  logic rowLegal;
  logic [CNT_W-1:0] effWait [NUM_BANKS];
  logic [NUM_BANKS-1:0] closedVec;
  logic [3*NUM_BANKS-1:0] allStrobes;
  logic [CNT_W-1:0] minWait;

  assign kindE    = cmdKindT'(cmdKind);
  assign rowLegal = (cmdRow != '1);

  always_comb begin
    cmdFlat = int'(cmdRank) * BANKS_PER_RANK + int'(cmdBank);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int RK = b / BANKS_PER_RANK;
    logic hit;
    logic [CNT_W-1:0] w;

    always_comb begin
      w = actWait[b];
      if (rrdWait[RK] > w) w = rrdWait[RK];
      if (xawWait[RK] > w) w = xawWait[RK];
    end

    assign effWait[b]   = w;
    assign closedVec[b] = !rowOpen[b];
    assign actReady[b]  = !rowOpen[b] && (w == '0);
    assign colReady[b]  = rowOpen[b] && colIdle[b];
    assign preReady[b]  = rowOpen[b] && preIdle[b];

    assign hit = (cmdFlat == b);
    assign strobe[b].act = hit && (kindE == CMD_ACT) && actReady[b] && rowLegal;
    assign strobe[b].col = hit && (kindE == CMD_COL) && colReady[b];
    assign strobe[b].pre = hit && (kindE == CMD_PRE) && preReady[b];
    assign allStrobes[3*b +: 3] = strobe[b];
  end

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    always_comb begin
      rankAct[r] = 1'b0;
      for (int i = 0; i < BANKS_PER_RANK; i++) begin
        rankAct[r] = rankAct[r] | strobe[r*BANKS_PER_RANK + i].act;
      end
    end
  end

  // smallest activate wait among closed banks, then mark every tie
  always_comb begin
    minWait = '1;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (closedVec[b] && effWait[b] < minWait) minWait = effWait[b];
    end
    for (int b = 0; b < NUM_BANKS; b++) begin
      earliestMask[b] = closedVec[b] && (effWait[b] == minWait);
    end
  end

  assign qryOpen = rowOpen[qryBank];
  assign qryRow  = openRow[qryBank];

  // R7: at most one bank strobe per cycle
  p_single_cmd_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(allStrobes));

  // R8: if any bank is closed, some bank is flagged earliest
  p_mask_present_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|closedVec) |-> (|earliestMask));

endmodule

// File: rtl/dramBankTracker.sv
module dramBankTracker
  import dbtPkg::*;
#(
  parameter int NUM_RANKS      = 2,
  parameter int BANKS_PER_RANK = 4,
  parameter int ROW_W          = 10,
  parameter int T_RCD          = 3,
  parameter int T_RP           = 3,
  parameter int T_RAS          = 6,
  parameter int T_RRD          = 2,
  parameter int T_XAW          = 10,
  parameter int ACT_LIMIT      = 2,
  parameter int MAX_COL        = 4,
  localparam int NUM_BANKS = NUM_RANKS * BANKS_PER_RANK,
  localparam int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int BANK_W    = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1,
  localparam int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           cmdKind,
  input  logic [RANK_W-1:0]    cmdRank,
  input  logic [BANK_W-1:0]    cmdBank,
  input  logic [ROW_W-1:0]     cmdRow,
  input  logic [IDX_W-1:0]     qryBank,
  output logic [NUM_BANKS-1:0] actReady,
  output logic [NUM_BANKS-1:0] colReady,
  output logic [NUM_BANKS-1:0] preReady,
  output logic [NUM_BANKS-1:0] earliestMask,
  output logic                 qryOpen,
  output logic [ROW_W-1:0]     qryRow
);

  localparam int CNT_W = $clog2(T_RAS + T_RP + T_XAW + T_RCD + T_RRD + 1);

  bankStrobeT       strobe  [NUM_BANKS];
  logic             rowOpen [NUM_BANKS];
  logic [ROW_W-1:0] openRow [NUM_BANKS];
  logic [CNT_W-1:0] actWait [NUM_BANKS];
  logic             colIdle [NUM_BANKS];
  logic             preIdle [NUM_BANKS];
  logic             rankAct [NUM_RANKS];
  logic [CNT_W-1:0] rrdWait [NUM_RANKS];
  logic [CNT_W-1:0] xawWait [NUM_RANKS];

  dbtControl #(
    .NUM_RANKS(NUM_RANKS), .BANKS_PER_RANK(BANKS_PER_RANK),
    .ROW_W(ROW_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cmdKind(cmdKind), .cmdRank(cmdRank), .cmdBank(cmdBank), .cmdRow(cmdRow),
    .qryBank(qryBank),
    .rowOpen(rowOpen), .openRow(openRow), .actWait(actWait),
    .colIdle(colIdle), .preIdle(preIdle),
    .rrdWait(rrdWait), .xawWait(xawWait),
    .strobe(strobe), .rankAct(rankAct),
    .actReady(actReady), .colReady(colReady), .preReady(preReady),
    .earliestMask(earliestMask), .qryOpen(qryOpen), .qryRow(qryRow)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dbtBankState #(
      .ROW_W(ROW_W), .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RP(T_RP),
      .T_RAS(T_RAS), .MAX_COL(MAX_COL)
    ) bank_i (
      .clk(clk), .rstN(rstN), .strobe(strobe[b]), .actRow(cmdRow),
      .rowOpen(rowOpen[b]), .openRow(openRow[b]), .actWait(actWait[b]),
      .colIdle(colIdle[b]), .preIdle(preIdle[b])
    );
  end

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    dbtRankWindow #(
      .CNT_W(CNT_W), .T_RRD(T_RRD), .T_XAW(T_XAW), .ACT_LIMIT(ACT_LIMIT)
    ) rank_i (
      .clk(clk), .rstN(rstN), .actAny(rankAct[r]),
      .rrdWait(rrdWait[r]), .xawWait(xawWait[r])
    );
  end

endmodule

// File: tb/dramBankTracker_tb_top.sv
`timescale 1ns/1ps
module dramBankTracker_tb_top;

  localparam int NR = 2, BPR = 4, NB = NR * BPR, ROW_W = 6;
  localparam int T_RCD = 3, T_RP = 3, T_RAS = 6, T_RRD = 2, T_XAW = 10;
  localparam int ACT_LIMIT = 2, MAX_COL = 4;
  localparam int NO_ROW = (1 << ROW_W) - 1;
  localparam int K_NONE = 0, K_ACT = 1, K_COL = 2, K_PRE = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cmdKind = '0;
  logic [0:0] cmdRank = '0;
  logic [1:0] cmdBank = '0;
  logic [ROW_W-1:0] cmdRow = '0;
  logic [2:0] qryBank = '0;
  logic [NB-1:0] actReady, colReady, preReady, earliestMask;
  logic qryOpen;
  logic [ROW_W-1:0] qryRow;

  always #2 clk = ~clk;

  dramBankTracker #(
    .NUM_RANKS(NR), .BANKS_PER_RANK(BPR), .ROW_W(ROW_W),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RRD(T_RRD),
    .T_XAW(T_XAW), .ACT_LIMIT(ACT_LIMIT), .MAX_COL(MAX_COL)
  ) dut_i (
    .clk(clk), .rstN(rstN), .cmdKind(cmdKind), .cmdRank(cmdRank),
    .cmdBank(cmdBank), .cmdRow(cmdRow), .qryBank(qryBank),
    .actReady(actReady), .colReady(colReady), .preReady(preReady),
    .earliestMask(earliestMask), .qryOpen(qryOpen), .qryRow(qryRow)
  );

  int n, checks, errors;
  bit finished;
  string tag;
  int openM [NB], accM [NB], colAt [NB], preAt [NB], actAt [NB];
  int rrdAt [NR], wpM [NR];
  int win [NR][ACT_LIMIT];

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int actWhen(int b);
    int r = b / BPR;
    return imax(actAt[b], imax(rrdAt[r], win[r][wpM[r]]));
  endfunction

  task automatic resetModel();
    for (int b = 0; b < NB; b++) begin
      openM[b] = -1; accM[b] = 0; colAt[b] = 0; preAt[b] = 0; actAt[b] = 0;
    end
    for (int r = 0; r < NR; r++) begin
      rrdAt[r] = 0; wpM[r] = 0;
      for (int i = 0; i < ACT_LIMIT; i++) win[r][i] = 0;
    end
  endtask

  task automatic cmp(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: got %h expected %h", tag, what, n, got, exp);
    end
  endtask

  task automatic checkAll();
    logic [NB-1:0] eA, eC, eP, eM;
    int minW, w;
    int qb;
    minW = 1 << 30;
    for (int b = 0; b < NB; b++) begin
      w = imax(actWhen(b) - n, 0);
      eA[b] = (openM[b] < 0) && (w == 0);
      eC[b] = (openM[b] >= 0) && (n >= colAt[b]);
      eP[b] = (openM[b] >= 0) && (n >= preAt[b]);
      if (openM[b] < 0 && w < minW) minW = w;
    end
    for (int b = 0; b < NB; b++) begin
      w = imax(actWhen(b) - n, 0);
      eM[b] = (openM[b] < 0) && (w == minW);
    end
    qb = int'(qryBank);
    cmp("actReady", int'(actReady), int'(eA));
    cmp("colReady", int'(colReady), int'(eC));
    cmp("preReady", int'(preReady), int'(eP));
    cmp("R8 earliestMask", int'(earliestMask), int'(eM));
    cmp("qryOpen", int'(qryOpen), (openM[qb] >= 0) ? 1 : 0);
    cmp("qryRow", int'(qryRow), (openM[qb] >= 0) ? openM[qb] : NO_ROW);
  endtask

  task automatic applyModel(int kind, int rk, int bk, int row);
    int b = rk * BPR + bk;
    case (kind)
      K_ACT: if (openM[b] < 0 && n >= actWhen(b) && row != NO_ROW) begin
        openM[b] = row; accM[b] = 0;
        colAt[b] = n + T_RCD;
        preAt[b] = imax(preAt[b], n + T_RAS);
        rrdAt[rk] = n + T_RRD;
        win[rk][wpM[rk]] = n + T_XAW;
        wpM[rk] = (wpM[rk] + 1) % ACT_LIMIT;
      end
      K_COL: if (openM[b] >= 0 && n >= colAt[b]) begin
        accM[b]++;
        if (accM[b] == MAX_COL) begin
          openM[b] = -1; accM[b] = 0;
          actAt[b] = imax(preAt[b], n) + T_RP;
        end
      end
      K_PRE: if (openM[b] >= 0 && n >= preAt[b]) begin
        openM[b] = -1; accM[b] = 0;
        actAt[b] = n + T_RP;
      end
      default: ;
    endcase
  endtask

  task automatic step(int kind, int rk, int bk, int row);
    qryBank = 3'(n % NB);
    #1;
    checkAll();
    cmdKind = 2'(kind); cmdRank = 1'(rk); cmdBank = 2'(bk); cmdRow = ROW_W'(row);
    applyModel(kind, rk, bk, row);
    @(negedge clk);
    n++;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    cmdKind = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    resetModel();
    n = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired at cycle %0d: got hang expected finish", n);
      summary();
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; finished = 0;
    doReset();

    // R1: reset state
    tag = "R1";
    step(K_NONE, 0, 0, 0);

    // R9 and R2: rank 1 bank 0 is flat index 4
    tag = "R9";
    step(K_ACT, 1, 0, 42);
    for (int i = 0; i < 8; i++) step(K_NONE, 0, 0, 0);

    // R4: back-to-back activates in one rank, the other rank free
    tag = "R4";
    step(K_ACT, 0, 0, 5);
    step(K_ACT, 0, 1, 6);
    step(K_ACT, 1, 1, 7);
    step(K_ACT, 0, 1, 6);

    // R5: third activate in rank 0 waits for the window
    tag = "R5";
    for (int i = 0; i < 12; i++) step(K_ACT, 0, 2, 9);

    // R2: column readiness after the activate
    tag = "R2";
    step(K_ACT, 0, 3, 11);
    for (int i = 0; i < 4; i++) step(K_NONE, 0, 0, 0);

    // R6: forced close after MAX_COL column accesses
    tag = "R6";
    for (int i = 0; i < MAX_COL + 1; i++) step(K_COL, 1, 0, 0);
    for (int i = 0; i < 5; i++) step(K_NONE, 0, 0, 0);

    // R3: precharge window and reopen delay
    tag = "R3";
    step(K_PRE, 0, 3, 0);
    for (int i = 0; i < 8; i++) step(K_PRE, 0, 3, 0);
    for (int i = 0; i < 4; i++) step(K_NONE, 0, 0, 0);

    // R7: illegal commands have no effect
    tag = "R7";
    step(K_COL, 0, 3, 0);
    step(K_PRE, 1, 0, 0);
    step(K_ACT, 1, 2, NO_ROW);
    step(K_ACT, 0, 0, 3);
    step(K_NONE, 0, 0, 0);

    // R8: random mixture with per-cycle comparison of all outputs
    tag = "R8";
    for (int i = 0; i < 4000; i++) begin
      int sel = int'($urandom % 8);
      int kind = (sel < 2) ? K_ACT : (sel < 5) ? K_COL : (sel < 7) ? K_PRE : K_NONE;
      step(kind, int'($urandom % NR), int'($urandom % BPR), int'($urandom % (NO_ROW + 1)));
    end

    // R1: reset in the middle of activity
    tag = "R1";
    doReset();
    step(K_NONE, 0, 0, 0);
    step(K_NONE, 0, 0, 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule